// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial bus in front of a 256-byte, byte-addressed memory. It oversamples the clock and data lines with the system clock and recognises START and STOP conditions. It shifts in a control byte, a word address and data bytes. It answers with acknowledge bits and read data through an open-drain enable output: when `sda_oe` is high, the pad pulls the data line low.

One address pointer serves both reads and writes, and it keeps its value from one transaction to the next. This gives three kinds of read:

- **Current-address read:** starts at the pointer's present value.
- **Random read:** a write of only the word address, then a repeated START and a read control byte.
- **Sequential read:** keeps returning bytes while the master acknowledges.

Each accepted write byte leaves the block as a one-cycle strobe carrying address and data, meant for a page-programming engine. The same strobe also updates the local register model of the array. A STOP that closes a write raises a commit pulse. While the engine reports busy, the block acknowledges nothing, so a master can poll for the end of a programming cycle.

Top module: `twm_slave`

## Requirements
- R1: A falling data line while the clock line is high is a START, and a rising one is a STOP; no data-line change during clock-high is taken as data. A START at any point, including inside a byte, restarts control-byte matching. A STOP at any point returns the slave to idle with its drive released, and no strobe is issued for the cut-off byte.
- R2: Both lines pass a two-flop synchronizer, and a new level is accepted only after it has held for two consecutive system clocks. A one-clock pulse on the data line during clock-high therefore neither starts nor stops a transfer, and it does not alter a received bit.
- R3: The control byte arrives most significant bit first. It is accepted only when bits 7..4 equal 4'b1010. Bits 3..1 are ignored, and bit 0 selects read (1) or write (0). After a rejected control byte the slave ignores every byte until the next START.
- R4: For each accepted received byte, the slave asserts `sda_oe` from the falling clock edge after the eighth bit until the falling edge that ends the ninth clock pulse.
- R5: While `busy_i` is high, no byte is acknowledged (the control byte included), no write strobe is issued, and the slave returns to idle.
- R6: In a write, the byte after the control byte loads the pointer. Each later byte produces one `wr_stb` pulse of one cycle, with `wr_addr` set to the pointer and `wr_data` to the byte, and writes the array.
- R7: After each written byte, only the low three pointer bits advance, wrapping within the aligned 8-byte page; the upper five bits do not change.
- R8: A read control byte that is not preceded by an address returns data starting at the current pointer, which is the last accessed address plus one.
- R9: A pointer loaded by an address-only write survives a repeated START, and the following read starts at that address.
- R10: After each read byte the pointer advances by one, and from 255 it wraps to 0. A master acknowledge brings the next byte. A master no-acknowledge leaves `sda_oe` low, and the slave waits for the next START.
- R11: `sda_oe` (both acknowledge and read data) changes only while the clock line is low.
- R12: A STOP that ends a write in which at least one data byte was strobed raises `wr_commit` for one cycle. An address-only write raises no commit.
- R13: After reset, `sda_oe`, `wr_stb` and `wr_commit` are low, the pointer is 0, and array location a holds a XOR 8'h5A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| busy_i | input | 1 | Programming engine busy; suppresses all acknowledges |
| sda_oe | output | 1 | High to pull the data line low |
| wr_stb | output | 1 | One-cycle strobe per accepted write byte |
| wr_addr | output | 8 | Address of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| wr_commit | output | 1 | One-cycle pulse on a STOP that ends a write with data |

## Verification
Two actions share a single falling clock edge: the release of the slave's acknowledge after a read control byte, and the drive of the first data bit. When that bit is 0, `sda_oe` must stay high without a gap; when it is 1, `sda_oe` must fall on that edge. The bench provokes both cases. It reads location 0 right after reset (value 8'h5A, top bit 0) and reads many random locations. It judges the result by comparing every sampled bit with its own memory model. A bench monitor also confirms that `sda_oe` never moves while the master holds the clock line high.

// File: rtl/twm_pkg.sv
`timescale 1ns/1ps
package twm_pkg;

    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA
    } twm_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } twm_evt_t;

    // value each array location takes on reset
    function automatic logic [BYTE_W-1:0] twm_init_byte(input logic [7:0] a);
        return a ^ 8'h5A;
    endfunction

endpackage

// File: rtl/twm_filter.sv
`timescale 1ns/1ps
module twm_filter #(
    parameter int STABLE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(STABLE + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1   <= 1'b1;
            s2   <= 1'b1;
            dout <= 1'b1;
            cnt  <= '0;
        end else begin
            s1 <= din;
            s2 <= s1;
            if (s2 != dout) begin
                if (cnt == CW'(STABLE - 1)) begin
                    dout <= s2;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end else begin
                cnt <= '0;
            end
        end
    end
endmodule

// File: rtl/twm_cond.sv
`timescale 1ns/1ps
module twm_cond
    import twm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl,
    input  logic     sda,
    output twm_evt_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    always_comb begin
        ev.scl_rise = scl & ~scl_p;
        ev.scl_fall = ~scl & scl_p;
        ev.start    = scl & scl_p & sda_p & ~sda;
        ev.stop     = scl & scl_p & ~sda_p & sda;
    end
endmodule

// File: rtl/twm_mem.sv
`timescale 1ns/1ps
module twm_mem
    import twm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= twm_init_byte(8'(i));
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/twm_proto.sv
`timescale 1ns/1ps
module twm_proto
    import twm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  twm_evt_t          ev,
    input  logic              sda,
    input  logic              busy,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit
);
    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
    localparam logic [3:0] BIT_LAST = 4'd7;
    localparam logic [3:0] BIT_FULL = 4'd8;
    localparam logic [3:0] BIT_ACK  = 4'd9;

    twm_state_e        state;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rnw, mack, wrote;

    function automatic logic [ADDR_W-1:0] page_inc(input logic [ADDR_W-1:0] p);
        return (p & ~PAGE_MASK) | ((p + ADDR_W'(1)) & PAGE_MASK);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            rnw       <= 1'b0;
            mack      <= 1'b0;
            wrote     <= 1'b0;
            wr_stb    <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            wr_commit <= 1'b0;
        end else begin
            wr_stb    <= 1'b0;
            wr_commit <= 1'b0;
            if (ev.start) begin
                state  <= ST_CTRL;
                bitcnt <= '0;
                sda_oe <= 1'b0;
                wrote  <= 1'b0;
            end else if (ev.stop) begin
                state     <= ST_IDLE;
                bitcnt    <= '0;
                sda_oe    <= 1'b0;
                wr_commit <= wrote;
                wrote     <= 1'b0;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_CTRL, ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise && bitcnt < BIT_FULL) begin
                            shreg  <= {shreg[BYTE_W-2:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == BIT_FULL) begin
                            bitcnt <= BIT_ACK;
                            if (busy) begin
                                state <= ST_IDLE;
                            end else if (state == ST_CTRL) begin
                                if (shreg[7:4] == DEV_CODE) begin
                                    sda_oe <= 1'b1;
                                    rnw    <= shreg[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_ADDR) begin
                                sda_oe <= 1'b1;
                                ptr    <= shreg[ADDR_W-1:0];
                            end else begin
                                sda_oe  <= 1'b1;
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= page_inc(ptr);
                                wrote   <= 1'b1;
                            end
                        end else if (ev.scl_fall && bitcnt == BIT_ACK) begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                            if (state == ST_CTRL) begin
                                if (rnw) begin
                                    state  <= ST_RDATA;
                                    shreg  <= rd_data;
                                    sda_oe <= ~rd_data[BYTE_W-1];
                                    ptr    <= ptr + ADDR_W'(1);
                                end else begin
                                    state <= ST_ADDR;
                                end
                            end else if (state == ST_ADDR) begin
                                state <= ST_WDATA;
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall && bitcnt < BIT_LAST) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == BIT_LAST) begin
                            sda_oe <= 1'b0;
                            bitcnt <= BIT_FULL;
                        end else if (ev.scl_rise && bitcnt == BIT_FULL) begin
                            mack   <= ~sda;
                            bitcnt <= BIT_ACK;
                        end else if (ev.scl_fall && bitcnt == BIT_ACK) begin
                            bitcnt <= '0;
                            if (mack) begin
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                                ptr    <= ptr + ADDR_W'(1);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/twm_slave.sv
`timescale 1ns/1ps
module twm_slave
    import twm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3,
    parameter int STABLE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              busy_i,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              wr_commit
);
    logic              scl_q, sda_q;
    twm_evt_t          ev;
    logic [ADDR_W-1:0] ptr;
    logic [BYTE_W-1:0] rd_data;

    twm_filter #(.STABLE(STABLE)) u_scl_flt (
        .clk(clk), .rst(rst), .din(scl_i), .dout(scl_q)
    );

    twm_filter #(.STABLE(STABLE)) u_sda_flt (
        .clk(clk), .rst(rst), .din(sda_i), .dout(sda_q)
    );

    twm_cond u_cond (
        .clk(clk), .rst(rst), .scl(scl_q), .sda(sda_q), .ev(ev)
    );

    twm_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
        .clk(clk), .rst(rst), .ev(ev), .sda(sda_q), .busy(busy_i),
        .rd_data(rd_data), .ptr(ptr), .sda_oe(sda_oe), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_commit(wr_commit)
    );

    twm_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk(clk), .rst(rst), .we(wr_stb), .waddr(wr_addr),
        .wdata(wr_data), .raddr(ptr), .rdata(rd_data)
    );
endmodule

// File: rtl/twm_slave_chk.sv
`timescale 1ns/1ps
module twm_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_q,
    input logic start_ev,
    input logic stop_ev,
    input logic busy_i,
    input logic sda_oe,
    input logic wr_stb,
    input logic wr_commit
);
    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_q);

    // R5
    busy_no_stb_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |-> !$past(busy_i));

    // R6
    stb_single_chk: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R12
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> $past(stop_ev));

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> !sda_oe);
endmodule

bind twm_slave twm_slave_chk chk_i (
    .clk(clk), .rst(rst), .scl_q(scl_q), .start_ev(ev.start),
    .stop_ev(ev.stop), .busy_i(busy_i), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .wr_commit(wr_commit)
);

// File: tb/twm_slave_tb_top.sv
`timescale 1ns/1ps
module twm_slave_tb_top;
    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, wr_stb, wr_commit;
    logic [7:0] wr_addr, wr_data;
    wire  sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    twm_slave dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .busy_i(busy),
        .sda_oe(sda_oe), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_commit(wr_commit)
    );

    int n_chk = 0, n_bad = 0;
    int stb_cnt = 0, commit_cnt = 0, r11_viol = 0;
    logic [7:0] last_wa = '0, last_wd = '0;
    logic prev_oe = 1'b0;
    logic [7:0] exp_mem [256];
    logic [7:0] eptr;

    always @(posedge clk) begin
        if (!rst) begin
            if (wr_stb) begin
                stb_cnt <= stb_cnt + 1;
                last_wa <= wr_addr;
                last_wd <= wr_data;
            end
            if (wr_commit) commit_cnt <= commit_cnt + 1;
        end
    end

    // drive must not move while the master holds the clock high
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && scl_m) r11_viol <= r11_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tq(); scl_m = 1'b1; tq(); sda_m = 1'b0; tq(); scl_m = 1'b0; tq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tq(); scl_m = 1'b1; tq(); sda_m = 1'b1; tq();
    endtask

    task automatic clk_bit(input logic b, input logic glitch, output logic seen);
        sda_m = b; tq();
        scl_m = 1'b1; tq();
        seen = sda_line;
        if (glitch) begin
            sda_m = ~b; @(negedge clk); sda_m = b;
            repeat (Q - 1) @(negedge clk);
        end else begin
            tq();
        end
        scl_m = 1'b0; tq();
    endtask

    task automatic send_byte(input logic [7:0] v, input logic glitch, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], glitch, s);
        clk_bit(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, 1'b0, s);
            v[i] = s;
        end
        clk_bit(~mack, 1'b0, s);
    endtask

    task automatic rd_bytes(input int n, input string req);
        logic [7:0] v;
        for (int k = 0; k < n; k++) begin
            recv_byte(k < n - 1, v);
            chk(req, v, exp_mem[eptr]);
            eptr = eptr + 8'd1;
        end
        chk("R10 released after no-ack", sda_oe, 0);
    endtask

    task automatic wr_txn(input logic [7:0] a, input int n, input logic glitch);
        logic ack;
        logic [7:0] d;
        int s0;
        bus_start();
        send_byte({4'b1010, 3'($urandom), 1'b0}, 1'b0, ack);
        chk("R3 write control ack", ack, 1);
        send_byte(a, 1'b0, ack);
        chk("R4 address ack", ack, 1);
        eptr = a;
        for (int k = 0; k < n; k++) begin
            d = 8'($urandom);
            s0 = stb_cnt;
            send_byte(d, glitch, ack);
            chk(glitch ? "R2 data ack under glitch" : "R4 data ack", ack, 1);
            chk("R6 strobe count", stb_cnt, s0 + 1);
            chk("R7 strobe address", last_wa, eptr);
            chk("R6 strobe data", last_wd, d);
            exp_mem[eptr] = d;
            eptr = {eptr[7:3], eptr[2:0] + 3'd1};
        end
        s0 = commit_cnt;
        bus_stop();
        repeat (8) @(negedge clk);
        chk("R12 commit count", commit_cnt, s0 + ((n > 0) ? 1 : 0));
    endtask

    task automatic cur_read(input int n);
        logic ack;
        bus_start();
        send_byte({4'b1010, 3'($urandom), 1'b1}, 1'b0, ack);
        chk("R8 read control ack", ack, 1);
        rd_bytes(n, "R8 current-address data");
        bus_stop();
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string req);
        logic ack;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        chk("R9 control ack", ack, 1);
        send_byte(a, 1'b0, ack);
        chk("R9 address ack", ack, 1);
        bus_start();
        send_byte(8'hA1, 1'b0, ack);
        chk("R9 repeated-start read ack", ack, 1);
        eptr = a;
        rd_bytes(n, req);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack, s;
        int s0, c0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
        eptr = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R13 sda_oe after reset", sda_oe, 0);
        chk("R13 wr_stb after reset", wr_stb, 0);
        chk("R13 wr_commit after reset", wr_commit, 0);

        // pointer 0 and init pattern; first bit 0 right after ack release
        bus_start();
        send_byte(8'hA1, 1'b0, ack);
        chk("R13 read ack after reset", ack, 1);
        rd_bytes(2, "R13 initial contents");
        bus_stop();

        wr_txn(8'h10, 3, 1'b0);
        rand_read(8'h10, 3, "R9 random read data");
        cur_read(2);

        // page wrap: 10 bytes from 0x2D stay inside 0x28..0x2F
        wr_txn(8'h2D, 10, 1'b0);
        rand_read(8'h28, 8, "R7 page contents");

        rand_read(8'hFE, 4, "R10 sequential wrap data");
        cur_read(1);

        // foreign device code
        s0 = stb_cnt; c0 = commit_cnt;
        bus_start();
        send_byte(8'hB0, 1'b0, ack);
        chk("R3 foreign code not acked", ack, 0);
        send_byte(8'h33, 1'b0, ack);
        chk("R3 byte after reject not acked", ack, 0);
        send_byte(8'h44, 1'b0, ack);
        chk("R3 data after reject not acked", ack, 0);
        bus_stop();
        chk("R3 no strobe after reject", stb_cnt, s0);
        chk("R3 no commit after reject", commit_cnt, c0);

        // select bits ignored
        bus_start();
        send_byte(8'hAE, 1'b0, ack);
        chk("R3 select bits ignored", ack, 1);
        bus_stop();

        // busy suppresses every acknowledge
        busy = 1'b1;
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        chk("R5 no ack while busy (write)", ack, 0);
        send_byte(8'h00, 1'b0, ack);
        chk("R5 no ack on next byte while busy", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hA1, 1'b0, ack);
        chk("R5 no ack while busy (read)", ack, 0);
        bus_stop();
        chk("R5 no strobe while busy", stb_cnt, s0);
        busy = 1'b0;
        c0 = commit_cnt;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        chk("R5 ack once idle", ack, 1);
        send_byte(8'h77, 1'b0, ack);
        chk("R4 address ack", ack, 1);
        bus_stop();
        repeat (8) @(negedge clk);
        chk("R12 no commit for address-only write", commit_cnt, c0);
        eptr = 8'h77;
        cur_read(1);

        // START inside a data byte
        s0 = stb_cnt;
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        send_byte(8'h40, 1'b0, ack);
        chk("R1 address ack", ack, 1);
        clk_bit(1'b1, 1'b0, s); clk_bit(1'b0, 1'b0, s); clk_bit(1'b1, 1'b0, s);
        bus_start();
        send_byte(8'hA1, 1'b0, ack);
        chk("R1 control ack after mid-byte START", ack, 1);
        eptr = 8'h40;
        rd_bytes(1, "R1 read after mid-byte START");
        bus_stop();
        chk("R1 no strobe for cut byte", stb_cnt, s0);

        // STOP inside a data byte
        bus_start();
        send_byte(8'hA0, 1'b0, ack);
        send_byte(8'h50, 1'b0, ack);
        clk_bit(1'b0, 1'b0, s); clk_bit(1'b1, 1'b0, s);
        bus_stop();
        repeat (4) @(negedge clk);
        chk("R1 drive released after STOP", sda_oe, 0);
        chk("R1 no strobe after mid-byte STOP", stb_cnt, s0);
        eptr = 8'h50;
        cur_read(1);

        // one-clock glitches on data during clock high
        wr_txn(8'h60, 2, 1'b1);
        rand_read(8'h60, 2, "R2 data written under glitch");

        // random mix
        for (int t = 0; t < 30; t++) begin
            case ($urandom % 3)
                0: wr_txn(8'($urandom), 1 + int'($urandom % 10), 1'b0);
                1: cur_read(1 + int'($urandom % 4));
                default: rand_read(8'($urandom), 1 + int'($urandom % 5), "R10 random sequential data");
            endcase
        end

        chk("R11 drive moved during clock high", r11_viol, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule